// File: doc/BRIEF.md
# Trim Wiper Register with Shutdown and Overwrite

This block holds the digital setting of a 256-position resistor string and turns it into tap-select lines for the analog ladder. Code zero places the wiper at the bottom end of the string, terminal B. Each higher code moves the wiper up one tap. The block also drives two terminal controls. One opens terminal A. The other shorts the wiper to terminal B. Both are asserted together while the block is in shutdown.

A command interface delivers each update as a strobe. The strobe carries a new code, a shutdown bit and an overwrite bit. At reset the block loads one of two values. If the fuse-programmed flag is set, it loads the permanently programmed value. Otherwise it loads midscale. Once the fuses are programmed, a new code is taken only while the overwrite bit is set. A later update with overwrite clear restores the fuse value. Shutdown never alters the stored code, so codes written during shutdown are applied as soon as shutdown is released. The stored code can be read back at all times.

Top module: `trim_wiper`

## Requirements
- R1: When reset is released with `fuse_locked` low, `rd_code` is 0x80 and `tap_sel` has only bit 128 set. Both terminal controls are low.
- R2: When reset is released with `fuse_locked` high, `rd_code` equals `fuse_code` and `tap_sel` has only bit `fuse_code` set.
- R3: Outside shutdown, `tap_sel` has exactly one bit set, and that bit's index equals `rd_code`. Code 0x00 selects bit 0 (terminal B) and code 0xFF selects bit 255.
- R4: With `fuse_locked` low, a cycle with `wr_en` high loads `wr_code`. The new code appears on `rd_code` and `tap_sel` after the clock edge that samples the strobe.
- R5: An accepted strobe with `wr_shdn` = 1 puts the block into shutdown. In shutdown, `term_a_open` and `wiper_to_b` are both 1, `tap_sel` has only bit 0 set, and `rd_code` keeps the stored code.
- R6: A code written during shutdown shows on `rd_code` while `tap_sel` stays at bit 0. After a strobe with `wr_shdn` = 0, `tap_sel` follows the most recently stored code.
- R7: With `fuse_locked` high, a strobe with `wr_ovr` = 0 does not change the stored code. `rd_code` equals the fuse value afterwards. The shutdown bit of that strobe is still honoured.
- R8: With `fuse_locked` high, a strobe with `wr_ovr` = 1 loads `wr_code`, the same way as an unlocked write.
- R9: With `fuse_locked` high, the first strobe with `wr_ovr` = 0 after an overwrite returns `rd_code` and `tap_sel` to the fuse value.
- R10: Reset clears both overwrite and shutdown. After reset with `fuse_locked` high, the fuse value is applied even if an overwrite code was active before.
- R11: In a cycle with `wr_en` low, `wr_code`, `wr_shdn` and `wr_ovr` have no effect on `rd_code` or the terminal controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fuse_locked | input | 1 | The fuse value has been permanently programmed |
| fuse_code | input | 8 | Permanently programmed code |
| wr_en | input | 1 | Update strobe from the command interface |
| wr_code | input | 8 | New wiper code |
| wr_shdn | input | 1 | Shutdown bit of the update |
| wr_ovr | input | 1 | Overwrite bit of the update |
| tap_sel | output | 256 | One-hot tap select; bit n selects tap n, where bit 0 is terminal B |
| term_a_open | output | 1 | Open-circuit terminal A |
| wiper_to_b | output | 1 | Short the wiper to terminal B |
| rd_code | output | 8 | Stored wiper code, for readback |

## Verification
The assertions assume that `fuse_locked` and `fuse_code` come from fuse sensing. They therefore treat both as constant between resets. The checks on fuse-value retention and revert (R7) compare against the present `fuse_code`. The stimulus changes the fuse inputs only while reset is held, and it drives every strobe one cycle wide between falling edges. Update patterns cover both ends of the code range, shutdown entry and release, and overwrite entry and exit. Idle cycles carry deliberately different values on the data inputs.

// File: rtl/trim_wiper_pkg.sv
package trim_wiper_pkg;
  parameter int unsigned DEF_CODE_W = 8;

  typedef struct packed {
    logic shdn;
    logic ovr;
  } wiper_mode_t;
endpackage

// File: rtl/trim_code_reg.sv
module trim_code_reg #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fuse_locked,
  input  logic [CODE_W-1:0] fuse_code,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              wr_shdn,
  input  logic              wr_ovr,
  output logic [CODE_W-1:0] code_d,
  output logic [CODE_W-1:0] code_q,
  output trim_wiper_pkg::wiper_mode_t mode_d,
  output trim_wiper_pkg::wiper_mode_t mode_q
);
  localparam logic [CODE_W-1:0] MIDSCALE = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] shadow_q;
  logic [CODE_W-1:0] shadow_d;
  logic              take_code;

  // Fuse locking rejects the code unless the overwrite bit accompanies it.
  assign take_code = !fuse_locked || wr_ovr;

  always_comb begin
    code_d   = code_q;
    mode_d   = mode_q;
    shadow_d = shadow_q;
    if (rst) begin
      code_d   = fuse_locked ? fuse_code : MIDSCALE;
      shadow_d = fuse_code;
      mode_d   = '0;
    end else if (wr_en) begin
      mode_d.shdn = wr_shdn;
      mode_d.ovr  = wr_ovr;
      code_d      = take_code ? wr_code : shadow_q;
    end
  end

  always_ff @(posedge clk) begin
    code_q   <= code_d;
    mode_q   <= mode_d;
    shadow_q <= shadow_d;
  end
endmodule

// File: rtl/trim_tap_decode.sv
module trim_tap_decode #(
  parameter int unsigned CODE_W = 8,
  localparam int unsigned NTAPS = 1 << CODE_W
) (
  input  logic              clk,
  input  logic [CODE_W-1:0] code_d,
  input  logic              shdn_d,
  output logic [NTAPS-1:0]  tap_sel
);
  // Shutdown parks the selection on tap zero, the B end of the string.
  logic [CODE_W-1:0] sel_code;
  assign sel_code = shdn_d ? '0 : code_d;

  for (genvar t = 0; t < NTAPS; t++) begin : g_tap
    always_ff @(posedge clk) begin
      tap_sel[t] <= (sel_code == CODE_W'(t));
    end
  end
endmodule

// File: rtl/trim_term_ctl.sv
module trim_term_ctl (
  input  logic clk,
  input  logic shdn_d,
  output logic term_a_open,
  output logic wiper_to_b
);
  always_ff @(posedge clk) begin
    term_a_open <= shdn_d;
    wiper_to_b  <= shdn_d;
  end
endmodule

// File: rtl/trim_wiper.sv
module trim_wiper #(
  parameter int unsigned CODE_W = trim_wiper_pkg::DEF_CODE_W,
  localparam int unsigned NTAPS = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fuse_locked,
  input  logic [CODE_W-1:0] fuse_code,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              wr_shdn,
  input  logic              wr_ovr,
  output logic [NTAPS-1:0]  tap_sel,
  output logic              term_a_open,
  output logic              wiper_to_b,
  output logic [CODE_W-1:0] rd_code
);
  logic [CODE_W-1:0]           code_d;
  trim_wiper_pkg::wiper_mode_t mode_d;
  trim_wiper_pkg::wiper_mode_t mode_q;

  trim_code_reg #(.CODE_W(CODE_W)) code_reg_i (
    .clk         (clk),
    .rst         (rst),
    .fuse_locked (fuse_locked),
    .fuse_code   (fuse_code),
    .wr_en       (wr_en),
    .wr_code     (wr_code),
    .wr_shdn     (wr_shdn),
    .wr_ovr      (wr_ovr),
    .code_d      (code_d),
    .code_q      (rd_code),
    .mode_d      (mode_d),
    .mode_q      (mode_q)
  );

  trim_tap_decode #(.CODE_W(CODE_W)) tap_decode_i (
    .clk     (clk),
    .code_d  (code_d),
    .shdn_d  (mode_d.shdn),
    .tap_sel (tap_sel)
  );

  trim_term_ctl term_ctl_i (
    .clk         (clk),
    .shdn_d      (mode_d.shdn),
    .term_a_open (term_a_open),
    .wiper_to_b  (wiper_to_b)
  );
endmodule

// File: rtl/trim_wiper_chk.sv
module trim_wiper_chk #(
  parameter int unsigned CODE_W = 8,
  localparam int unsigned NTAPS = 1 << CODE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              fuse_locked,
  input logic [CODE_W-1:0] fuse_code,
  input logic              wr_en,
  input logic [CODE_W-1:0] wr_code,
  input logic              wr_ovr,
  input logic [NTAPS-1:0]  tap_sel,
  input logic              term_a_open,
  input logic              wiper_to_b,
  input logic [CODE_W-1:0] rd_code
);
  AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(tap_sel) == 1); // R3

  AST_TAP_FOLLOWS_CODE: assert property (@(posedge clk) disable iff (rst)
    !term_a_open |-> tap_sel[rd_code]); // R3

  AST_SHDN_TAP_B: assert property (@(posedge clk) disable iff (rst)
    term_a_open |-> tap_sel[0]); // R5

  AST_SHDN_PAIR: assert property (@(posedge clk) disable iff (rst)
    term_a_open == wiper_to_b); // R5

  AST_UNLOCKED_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!fuse_locked && wr_en) |=> (rd_code == $past(wr_code))); // R4

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fuse_locked && wr_en && !wr_ovr) |=> (rd_code == fuse_code)); // R7

  AST_OVR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (fuse_locked && wr_en && wr_ovr) |=> (rd_code == $past(wr_code))); // R8

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(rd_code) && $stable(term_a_open))); // R11
endmodule

bind trim_wiper trim_wiper_chk #(.CODE_W(CODE_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .fuse_locked (fuse_locked),
  .fuse_code   (fuse_code),
  .wr_en       (wr_en),
  .wr_code     (wr_code),
  .wr_ovr      (wr_ovr),
  .tap_sel     (tap_sel),
  .term_a_open (term_a_open),
  .wiper_to_b  (wiper_to_b),
  .rd_code     (rd_code)
);

// File: tb/trim_wiper_tb_top.sv
`timescale 1ns/1ps
module trim_wiper_tb_top;
  localparam int CW = 8;
  localparam int NT = 1 << CW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fuse_locked = 1'b0;
  logic [CW-1:0] fuse_code = 8'h3C;
  logic          wr_en = 1'b0;
  logic [CW-1:0] wr_code = '0;
  logic          wr_shdn = 1'b0;
  logic          wr_ovr = 1'b0;
  logic [NT-1:0] tap_sel;
  logic          term_a_open;
  logic          wiper_to_b;
  logic [CW-1:0] rd_code;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  trim_wiper dut_i (
    .clk         (clk),
    .rst         (rst),
    .fuse_locked (fuse_locked),
    .fuse_code   (fuse_code),
    .wr_en       (wr_en),
    .wr_code     (wr_code),
    .wr_shdn     (wr_shdn),
    .wr_ovr      (wr_ovr),
    .tap_sel     (tap_sel),
    .term_a_open (term_a_open),
    .wiper_to_b  (wiper_to_b),
    .rd_code     (rd_code)
  );

  // Row fields: {en, shdn, ovr, code[7:0], expected code[7:0], expected shutdown}
  localparam logic [19:0] VEC [9] = '{
    {1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0},
    {1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF, 1'b0},
    {1'b1, 1'b0, 1'b0, 8'h01, 8'h01, 1'b0},
    {1'b1, 1'b1, 1'b0, 8'h5A, 8'h5A, 1'b1},
    {1'b1, 1'b1, 1'b0, 8'h33, 8'h33, 1'b1},
    {1'b0, 1'b0, 1'b1, 8'h99, 8'h33, 1'b1},
    {1'b1, 1'b0, 1'b0, 8'h77, 8'h77, 1'b0},
    {1'b0, 1'b1, 1'b0, 8'h12, 8'h77, 1'b0},
    {1'b1, 1'b0, 1'b1, 8'hC4, 8'hC4, 1'b0}
  };

  task automatic chk(input string req, input logic [NT-1:0] act, input logic [NT-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_state(input string req, input logic [CW-1:0] code, input logic sd);
    logic [NT-1:0] onehot;
    onehot = '0;
    onehot[sd ? 0 : int'(code)] = 1'b1;
    chk({req, " code"}, NT'(rd_code), NT'(code));
    chk({req, " taps"}, tap_sel, onehot);
    chk({req, " terminals"}, NT'({term_a_open, wiper_to_b}), NT'({sd, sd}));
  endtask

  task automatic strobe(input logic en, input logic sd, input logic ov, input logic [CW-1:0] code);
    @(negedge clk);
    wr_en = en; wr_shdn = sd; wr_ovr = ov; wr_code = code;
    @(negedge clk);
    wr_en = 1'b0; wr_shdn = ~sd; wr_ovr = ~ov; wr_code = ~code;
  endtask

  task automatic do_reset(input logic locked);
    @(negedge clk);
    rst = 1'b1; fuse_locked = locked;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    expect_state("R1 midscale after reset", 8'h80, 1'b0);

    // R3 R4 R5 R6 R11 through the vector table, unlocked
    foreach (VEC[i]) begin
      strobe(VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16:9]);
      expect_state($sformatf("R4/R5/R6/R11 row %0d", i), VEC[i][8:1], VEC[i][0]);
    end

    do_reset(1'b1);
    expect_state("R2 fuse value after reset", 8'h3C, 1'b0);
    strobe(1'b1, 1'b0, 1'b0, 8'h10);
    expect_state("R7 locked write ignored", 8'h3C, 1'b0);
    strobe(1'b1, 1'b0, 1'b1, 8'h10);
    expect_state("R8 overwrite applied", 8'h10, 1'b0);
    strobe(1'b1, 1'b0, 1'b1, 8'hFE);
    expect_state("R8 second overwrite", 8'hFE, 1'b0);
    strobe(1'b1, 1'b0, 1'b0, 8'h55);
    expect_state("R9 revert to fuse", 8'h3C, 1'b0);
    strobe(1'b1, 1'b1, 1'b0, 8'h66);
    expect_state("R7 locked shutdown honoured", 8'h3C, 1'b1);
    strobe(1'b1, 1'b0, 1'b1, 8'hC0);
    expect_state("R8 overwrite after shutdown", 8'hC0, 1'b0);
    do_reset(1'b1);
    expect_state("R10 reset drops overwrite", 8'h3C, 1'b0);
    strobe(1'b1, 1'b1, 1'b1, 8'h21);
    do_reset(1'b1);
    expect_state("R10 reset drops shutdown", 8'h3C, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule